// File: doc/BRIEF.md
# Slow-Clock Event Delay and Combine Stage

This block is the output stage of a low-frequency real-time clock running on a 32768 Hz slow clock. Three compare-match pulses, one per channel, enter the block. Each pulse is delayed by a programmable number of slow-clock cycles. A single 4-bit delay code, shared by all channels, sets that delay through a non-linear table. A 3-bit channel mask then selects which delayed pulses are ORed into one combined event.

The block also holds the clock's control word and its 32-bit subsecond counter. The control word carries these fields: a run enable, a counter-clear bit that clears itself, an enable for a radio-sync square wave at half the slow-clock rate, and an enable for a 4 kHz reference. The 4 kHz reference is taken from bit 19 of the counter. Software writes the whole control word in one cycle through a plain write strobe and reads it back at any time.

Top module: `rtc_evt_out`

## Requirements
- R1: After reset, the read-back word, the counter, both derived outputs and all event outputs are 0.
- R2: The control word fields sit at these positions: run at bit 0, sync-toggle enable at bit 1, 4 kHz enable at bit 2, counter clear at bit 7, delay code at bits 11:8 and channel mask at bits 18:16. Every other bit reads 0 and ignores writes.
- R3: While run is 1, the counter advances by 2^17 on each slow-clock edge, wrapping modulo 2^32. While run is 0, the counter holds its value.
- R4: Writing 1 to bit 7 clears the counter on the next edge, whatever the run setting. Bit 7 reads 1 for exactly one cycle and then reads 0 again.
- R5: With its enable set, the sync output inverts on every edge. With its enable clear, the sync output is 0 from the next edge on.
- R6: The 4 kHz output equals counter bit 19 when both run and the 4 kHz enable are 1. Otherwise it is 0.
- R7: Delay codes 0 through 13 give 0, 1, 2, 4, 8, 16, 32, 48, 64, 80, 96, 112, 128 and 144 cycles. Codes 14 and 15 give 0 cycles. A delay of 0 passes the input pulse through in the same cycle.
- R8: The one delay code applies to all three channels. Pulses that arrive together also leave together.
- R9: A new pulse on a channel that still has a delay pending restarts that channel's countdown. Only one delayed pulse is produced, counted from the newer input.
- R10: The combined event is the OR of the delayed pulses whose mask bit is set. Mask bit n selects channel n. A mask of 0 gives no combined event.
- R11: A single-cycle input pulse produces exactly one single-cycle delayed pulse and, when the channel is selected by the mask, exactly one combined pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz slow clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Loads the control word from wr_data at the edge |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word, reserved bits 0 |
| evt_in | input | 3 | Compare-match pulses, one bit per channel |
| evt_dly | output | 3 | Delayed pulses, one bit per channel |
| evt_comb | output | 1 | Masked OR of the delayed pulses |
| subsec | output | 32 | Subsecond counter value |
| upd_tick | output | 1 | Radio-sync square wave at half the clock rate |
| ref_4k | output | 1 | Gated 4 kHz reference from counter bit 19 |

## Verification
A write lands at the edge that samples it. Counter steps, the self-clear of bit 7, and sync toggles then appear one edge later. The bench drives inputs and samples on the falling edge, so each expected value is counted in whole edges from that point.

A delayed pulse is due exactly D cycles after the cycle that holds the input pulse, where D is the decoded delay. A delay of 0 gives a pulse in the same cycle, through a combinational path. The bench therefore samples 1 ns after each falling edge and records the index of the first cycle in which the output is seen. All sixteen delay codes are swept on every channel, and all eight masks are swept on every channel.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;

    localparam int NUM_CH      = 3;
    localparam int DLY_CODE_W  = 4;
    localparam int DLY_CNT_W   = 8;
    localparam int WORD_W      = 32;

    localparam int RUN_BIT     = 0;
    localparam int UPD_BIT     = 1;
    localparam int REF_BIT     = 2;
    localparam int CLR_BIT     = 7;
    localparam int DLY_LSB     = 8;
    localparam int MASK_LSB    = 16;

    typedef struct packed {
        logic [NUM_CH-1:0]     mask;
        logic [DLY_CODE_W-1:0] dly_code;
        logic                  clr;
        logic                  ref_en;
        logic                  upd_en;
        logic                  run;
    } ctl_t;

    // Non-linear code table: powers of two up to 8, then steps of 16.
    function automatic logic [DLY_CNT_W-1:0] dly_cycles(input logic [DLY_CODE_W-1:0] code);
        logic [DLY_CNT_W-1:0] r;
        if (code == '0)
            r = '0;
        else if (code <= DLY_CODE_W'(4))
            r = DLY_CNT_W'(1) << (code - DLY_CODE_W'(1));
        else if (code <= DLY_CODE_W'(13))
            r = DLY_CNT_W'(code - DLY_CODE_W'(4)) << 4;
        else
            r = '0;
        return r;
    endfunction

endpackage

// File: rtl/rtc_ctl_reg.sv
module rtc_ctl_reg
    import rtc_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output ctl_t              ctl_o,
    output logic [WORD_W-1:0] rd_data_o
);

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        // Clear request lives for one cycle only.
        if (ctl_q.clr)
            ctl_d.clr = 1'b0;
        if (wr_en) begin
            ctl_d.run      = wr_data[RUN_BIT];
            ctl_d.upd_en   = wr_data[UPD_BIT];
            ctl_d.ref_en   = wr_data[REF_BIT];
            ctl_d.clr      = wr_data[CLR_BIT];
            ctl_d.dly_code = wr_data[DLY_LSB +: DLY_CODE_W];
            ctl_d.mask     = wr_data[MASK_LSB +: NUM_CH];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctl_q <= '0;
        else
            ctl_q <= ctl_d;
    end

    always_comb begin
        rd_data_o                          = '0;
        rd_data_o[RUN_BIT]                 = ctl_q.run;
        rd_data_o[UPD_BIT]                 = ctl_q.upd_en;
        rd_data_o[REF_BIT]                 = ctl_q.ref_en;
        rd_data_o[CLR_BIT]                 = ctl_q.clr;
        rd_data_o[DLY_LSB +: DLY_CODE_W]   = ctl_q.dly_code;
        rd_data_o[MASK_LSB +: NUM_CH]      = ctl_q.mask;
    end

    assign ctl_o = ctl_q;

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[WORD_W-1:MASK_LSB+NUM_CH],
                              wr_data[MASK_LSB-1:DLY_LSB+DLY_CODE_W],
                              wr_data[CLR_BIT-1:REF_BIT+1]};

    // R4: a pending clear drops by itself unless rewritten
    a_r4_clr_self: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.clr && !wr_en |=> !ctl_q.clr);

    // R2: a write is reflected in the read-back fields one edge later
    a_r2_write_run: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data_o[RUN_BIT] == $past(wr_data[RUN_BIT]));

endmodule

// File: rtl/rtc_subsec_cnt.sv
module rtc_subsec_cnt #(
    parameter int          CNT_W = 32,
    parameter logic [31:0] INCR  = 32'h0002_0000,
    parameter int          TAP   = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             upd_en,
    input  logic             ref_en,
    output logic [CNT_W-1:0] cnt_o,
    output logic             upd_o,
    output logic             ref_o
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(INCR);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             upd;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)
            st_d.cnt = '0;
        else if (run)
            st_d.cnt = st_q.cnt + STEP;
        st_d.upd = upd_en ? ~st_q.upd : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign upd_o = st_q.upd;
    assign ref_o = run & ref_en & st_q.cnt[TAP];

    // R3: frozen when not running
    a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !clr |=> $stable(st_q.cnt));

    // R3: fixed step when running
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        run && !clr |=> st_q.cnt == $past(st_q.cnt) + STEP);

    // R4: clear takes effect at the next edge
    a_r4_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> st_q.cnt == '0);

    // R5: sync output inverts each edge while enabled
    a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> st_q.upd != $past(st_q.upd));

endmodule

// File: rtl/rtc_evt_delay.sv
module rtc_evt_delay #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic [CNT_W-1:0] dly_len,
    output logic             evt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } dly_st_t;

    dly_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (evt_i && dly_len != '0)
            st_d.cnt = dly_len;
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign evt_o = (dly_len == '0) ? evt_i : (st_q.cnt == CNT_W'(1));

    // R9: a fresh pulse reloads the full delay
    a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i && dly_len != '0 |=> st_q.cnt == $past(dly_len));

    // R11: countdown runs one step per edge
    a_r11_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt != '0 && !evt_i |=> st_q.cnt == $past(st_q.cnt) - CNT_W'(1));

endmodule

// File: rtl/rtc_evt_out.sv
module rtc_evt_out
    import rtc_evt_pkg::*;
#(
    parameter int          CNT_W = 32,
    parameter logic [31:0] INCR  = 32'h0002_0000,
    parameter int          TAP   = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic [NUM_CH-1:0] evt_in,
    output logic [NUM_CH-1:0] evt_dly,
    output logic              evt_comb,
    output logic [CNT_W-1:0]  subsec,
    output logic              upd_tick,
    output logic              ref_4k
);

    ctl_t                 ctl;
    logic [DLY_CNT_W-1:0] dly_len;

    rtc_ctl_reg u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ctl_o     (ctl),
        .rd_data_o (rd_data)
    );

    rtc_subsec_cnt #(
        .CNT_W (CNT_W),
        .INCR  (INCR),
        .TAP   (TAP)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctl.run),
        .clr    (ctl.clr),
        .upd_en (ctl.upd_en),
        .ref_en (ctl.ref_en),
        .cnt_o  (subsec),
        .upd_o  (upd_tick),
        .ref_o  (ref_4k)
    );

    // One decode of the shared delay code feeds every channel.
    assign dly_len = dly_cycles(ctl.dly_code);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        rtc_evt_delay #(
            .CNT_W (DLY_CNT_W)
        ) u_dly (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_i   (evt_in[g]),
            .dly_len (dly_len),
            .evt_o   (evt_dly[g])
        );
    end

    assign evt_comb = |(evt_dly & ctl.mask);

    // R10: empty mask never yields a combined event
    a_r10_no_mask: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.mask == '0 |-> !evt_comb);

    // R10: a combined event needs at least one delayed event
    a_r10_comb_src: assert property (@(posedge clk) disable iff (!rst_n)
        evt_comb |-> evt_dly != '0);

    // R6: reference is silent while the clock is halted
    a_r6_ref_halt: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.run |-> !ref_4k);

endmodule

// File: tb/sim_rtc_evt_out.sv
module sim_rtc_evt_out;

    localparam longint INC = 64'h2_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [2:0]  evt_in = '0;
    logic [2:0]  evt_dly;
    logic        evt_comb;
    logic [31:0] subsec;
    logic        upd_tick;
    logic        ref_4k;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtc_evt_out u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .evt_in   (evt_in),
        .evt_dly  (evt_dly),
        .evt_comb (evt_comb),
        .subsec   (subsec),
        .upd_tick (upd_tick),
        .ref_4k   (ref_4k)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    function automatic int exp_delay(input int code);
        if (code == 0 || code > 13) return 0;
        if (code <= 4) return 1 << (code - 1);
        return 16 * (code - 4);
    endfunction

    // R7 R8 R11: sweep one channel at one delay code
    task automatic measure(input int ch, input int code);
        int d, hits, first, chits, others;
        d = exp_delay(code);
        wr((32'(code) << 8) | 32'h0007_0000);
        hits = 0; first = -1; chits = 0; others = 0;
        evt_in = '0;
        evt_in[ch] = 1'b1;
        for (int i = 0; i <= d + 3; i++) begin
            if (i > 0) begin
                @(negedge clk);
                evt_in = '0;
            end
            #1;
            if (evt_dly[ch]) begin
                hits++;
                if (first < 0) first = i;
            end
            if (evt_comb) chits++;
            for (int k = 0; k < 3; k++)
                if (k != ch && evt_dly[k]) others++;
        end
        chk(first == d, (ch == 0) ? "R7 delay" : "R8 delay", first, d);
        chk(hits == 1, "R11 pulse count", hits, 1);
        chk(chits == 1, "R11 comb count", chits, 1);
        chk(others == 0, "R8 other channels", others, 0);
    endtask

    initial begin
        logic [31:0] held;
        logic        prev;
        int          hits, first;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1
        chk(rd_data == 0, "R1 rd_data", rd_data, 0);
        chk(subsec == 0, "R1 subsec", subsec, 0);
        chk({upd_tick, ref_4k, evt_dly, evt_comb} == 0, "R1 outputs",
            {upd_tick, ref_4k, evt_dly, evt_comb}, 0);

        // R2
        wr(32'hFFF8_F078);
        chk(rd_data == 0, "R2 reserved", rd_data, 0);
        wr(32'h0007_0F06);
        chk(rd_data == 32'h0007_0F06, "R2 fields", rd_data, 32'h0007_0F06);
        wr(32'h0);

        // R3 frozen then running
        repeat (5) @(negedge clk);
        chk(subsec == 0, "R3 frozen at zero", subsec, 0);
        wr(32'h1);
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            chk(subsec == 32'(k * INC), "R3 step", subsec, 32'(k * INC));
        end
        wr(32'h0);
        held = subsec;
        repeat (5) @(negedge clk);
        chk(subsec == held, "R3 hold", subsec, held);

        // R4 self-clearing reset
        wr(32'h81);
        chk(rd_data[7] == 1'b1, "R4 bit set", rd_data[7], 1);
        @(negedge clk);
        chk(subsec == 0, "R4 cleared", subsec, 0);
        chk(rd_data[7] == 1'b0, "R4 bit self clear", rd_data[7], 0);
        @(negedge clk);
        chk(subsec == 32'(INC), "R4 resumes", subsec, 32'(INC));

        // R6 gating
        wr(32'h5);
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            chk(ref_4k == subsec[19], "R6 follows bit 19", ref_4k, subsec[19]);
        end
        wr(32'h1);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            chk(ref_4k == 1'b0, "R6 own enable off", ref_4k, 0);
        end
        wr(32'h5);
        while (subsec[19:17] != 3'b100) @(negedge clk);
        wr(32'h4);
        chk(subsec[19] == 1'b1, "R6 bit 19 high while halted", subsec[19], 1);
        chk(ref_4k == 1'b0, "R6 run off", ref_4k, 0);

        // R5 sync toggle
        wr(32'h2);
        prev = upd_tick;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(upd_tick != prev, "R5 toggles", upd_tick, !prev);
            prev = upd_tick;
        end
        wr(32'h0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(upd_tick == 1'b0, "R5 held low", upd_tick, 0);
        end

        // R7 R8 R11 full delay sweep
        for (int ch = 0; ch < 3; ch++)
            for (int code = 0; code < 16; code++)
                measure(ch, code);

        // R8 simultaneous pulses leave together
        wr(32'h0007_0200);
        evt_in = 3'b111;
        hits = 0; first = -1;
        for (int i = 0; i <= 5; i++) begin
            if (i > 0) begin
                @(negedge clk);
                evt_in = '0;
            end
            #1;
            if (evt_dly != 0) begin
                hits++;
                if (first < 0) first = i;
                chk(evt_dly == 3'b111, "R8 aligned", evt_dly, 3'b111);
            end
        end
        chk(first == 2 && hits == 1, "R8 shared delay", first, 2);

        // R9 restart: 4-cycle delay, second pulse at cycle 2
        wr(32'h0007_0300);
        evt_in = 3'b010;
        hits = 0; first = -1;
        for (int i = 0; i <= 10; i++) begin
            if (i > 0) begin
                @(negedge clk);
                evt_in = (i == 2) ? 3'b010 : 3'b000;
            end
            #1;
            if (evt_dly[1]) begin
                hits++;
                if (first < 0) first = i;
            end
        end
        chk(first == 6, "R9 restart time", first, 6);
        chk(hits == 1, "R9 single output", hits, 1);

        // R10 mask sweep at zero delay
        for (int m = 0; m < 8; m++) begin
            wr(32'(m) << 16);
            for (int ch = 0; ch < 3; ch++) begin
                @(negedge clk);
                evt_in = '0;
                evt_in[ch] = 1'b1;
                #1;
                chk(evt_comb == m[ch], "R10 mask select", evt_comb, m[ch]);
                @(negedge clk);
                evt_in = '0;
                #1;
                chk(evt_comb == 1'b0, "R10 idle", evt_comb, 0);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule